// File: doc/BRIEF.md
# UART Transmit DMA Engine

This block moves a run of bytes from memory into a UART transmitter with no processor involvement per byte. Software programs a start address and a byte count through a small 8-bit register bank, sets the enable bit and writes the start bit. The engine then fetches one byte at a time over a simple memory read port. It offers each byte on a valid/ready transmit-data interface and waits until the transmitter accepts it.

The count register is encoded as length minus one: a count of 0 moves one byte and a count of 255 moves 256 bytes. When the last byte is accepted, a sticky done flag is set. An interrupt output follows that flag when interrupts are enabled. A second sticky flag records any processor write to the UART data register made while a transfer is running, since such a write would corrupt the stream. Two 2-bit priority fields, one for interrupts and one for bus access, are stored and driven out unchanged.

Top module: `uart_tx_dma`

## Requirements
- R1: After reset every register reads 0, and irq, txValid and memReq are low.
- R2: A write to CTRL (address 1) with bit1 (start) = 1 and bit0 (enable) = 1 starts a transfer when idle. A CTRL write with bit0 = 0, or with bit1 = 0, starts nothing: memReq stays low and busy stays 0.
- R3: With COUNT (address 3) = N, exactly N+1 bytes are sent. Byte i is read from address start+i modulo 2^16, where start is {ADDRH (address 5), ADDRL (address 4)}.
- R4: Each byte is offered with txValid high and txData stable until txReady is high, and exactly one byte is handed over per valid/ready cycle.
- R5: STAT (address 2) bit0 (done) is set on the edge at which the last byte is handed over. It stays set until software clears it.
- R6: irq is high exactly when the done flag is 1 and CFG (address 0) bit0 (interrupt enable) is 1.
- R7: A cpuTxWrite pulse while busy sets STAT bit1 (collision). A cpuTxWrite pulse while idle leaves that bit unchanged.
- R8: Writing 0 to a STAT flag bit clears it and writing 1 leaves it alone. A hardware set in the same cycle as a clear wins.
- R9: CFG bits [2:1] drive intPrio and bits [4:3] drive busPrio unchanged, and both fields read back as written.
- R10: A start write while a transfer runs is ignored, and the running transfer continues unchanged.
- R11: Writing CTRL bit0 = 0 during a transfer aborts it: the engine returns to idle, sends no further byte and does not set done.
- R12: STAT bit2 (busy) reads 1 from the start edge until the edge of the last handover, then reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | REG_AW | Register address (read and write) |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational from regAddr) |
| memReq | output | 1 | Memory read request, data is due on the next cycle |
| memAddr | output | ADDR_W | Memory read address |
| memRdata | input | 8 | Memory read data, valid the cycle after memReq |
| txValid | output | 1 | Byte offered to the UART |
| txData | output | 8 | Byte offered to the UART |
| txReady | input | 1 | UART can accept a byte |
| cpuTxWrite | input | 1 | Processor write to the UART data register |
| irq | output | 1 | Completion interrupt |
| intPrio | output | 2 | Stored interrupt priority |
| busPrio | output | 2 | Stored bus-access priority |

## Verification
Register writes take effect at the next rising edge, so busy and the priority outputs are read on the falling edge that follows a write. A byte first appears on txValid two cycles after the start edge: one fetch cycle, one cycle for memory data, then the offer. Done and busy change at the edge of the last handshake. The bench drives txReady on falling edges and decides at that moment whether the next rising edge completes a handshake, recording the byte then. Count, content and flags are compared only once busy reads 0, and abort and ignored-start cases are judged by the bytes seen at the port.

// File: rtl/uart_tx_dma_pkg.sv
package uart_tx_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_SEND  = 2'd3
  } dmaState_t;

  typedef struct packed {
    logic start;
    logic fetch;
    logic capture;
    logic handoff;
    logic finish;
    logic busy;
  } dmaStrobe_t;

  localparam logic [2:0] REG_CFG   = 3'd0;
  localparam logic [2:0] REG_CTRL  = 3'd1;
  localparam logic [2:0] REG_STAT  = 3'd2;
  localparam logic [2:0] REG_COUNT = 3'd3;
  localparam logic [2:0] REG_ADDR0 = 3'd4;

endpackage

// File: rtl/uart_tx_dma_ctrl.sv
module uart_tx_dma_ctrl
  import uart_tx_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       enable,
  input  logic       lastByte,
  input  logic       txReady,
  output dmaStrobe_t strobe,
  output logic       txValid,
  output logic       memReq
);

  dmaState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    strobe      = '0;
    strobe.busy = (state != ST_IDLE);
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          strobe.start = 1'b1;
          nextState    = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (enable) begin
          strobe.fetch = 1'b1;
          nextState    = ST_WAIT;
        end else begin
          nextState = ST_IDLE;
        end
      end
      ST_WAIT: begin
        if (enable) begin
          strobe.capture = 1'b1;
          nextState      = ST_SEND;
        end else begin
          nextState = ST_IDLE;
        end
      end
      ST_SEND: begin
        if (!enable) begin
          nextState = ST_IDLE;
        end else if (txReady) begin
          strobe.handoff = 1'b1;
          if (lastByte) begin
            strobe.finish = 1'b1;
            nextState     = ST_IDLE;
          end else begin
            nextState = ST_FETCH;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign txValid = (state == ST_SEND) && enable;
  assign memReq  = (state == ST_FETCH) && enable;

endmodule

// File: rtl/uart_tx_dma_dp.sv
module uart_tx_dma_dp
  import uart_tx_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic [7:0]        memRdata,
  input  logic              cpuTxWrite,
  input  dmaStrobe_t        strobe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        txData,
  output logic              startReq,
  output logic              enable,
  output logic              lastByte,
  output logic              irq,
  output logic [1:0]        intPrio,
  output logic [1:0]        busPrio,
  output logic              doneFlag,
  output logic              collFlag
);

  localparam int ADDR_BYTES = (ADDR_W + 7) / 8;
  localparam int CNT_W      = 8;

  logic                    intEnQ;
  logic [1:0]              intPrioQ, busPrioQ;
  logic                    enableQ;
  logic [CNT_W-1:0]        countQ, remainQ;
  logic [ADDR_BYTES*8-1:0] startAddrQ;
  logic [ADDR_W-1:0]       ptrQ;
  logic [7:0]              dataQ;
  logic                    doneQ, collQ;

  logic wrCfg, wrCtrl, wrStat, wrCount;
  assign wrCfg   = regWe && (regAddr == REG_AW'(REG_CFG));
  assign wrCtrl  = regWe && (regAddr == REG_AW'(REG_CTRL));
  assign wrStat  = regWe && (regAddr == REG_AW'(REG_STAT));
  assign wrCount = regWe && (regAddr == REG_AW'(REG_COUNT));

  assign startReq = wrCtrl && regWdata[1] && regWdata[0];

  // software-visible configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEnQ     <= 1'b0;
      intPrioQ   <= '0;
      busPrioQ   <= '0;
      enableQ    <= 1'b0;
      countQ     <= '0;
      startAddrQ <= '0;
    end else begin
      if (wrCfg) begin
        intEnQ   <= regWdata[0];
        intPrioQ <= regWdata[2:1];
        busPrioQ <= regWdata[4:3];
      end
      if (wrCtrl)  enableQ <= regWdata[0];
      if (wrCount) countQ  <= regWdata[CNT_W-1:0];
      for (int b = 0; b < ADDR_BYTES; b++) begin
        if (regWe && (regAddr == REG_AW'(int'(REG_ADDR0) + b)))
          startAddrQ[b*8 +: 8] <= regWdata;
      end
    end
  end

  // transfer progress
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ    <= '0;
      remainQ <= '0;
      dataQ   <= '0;
    end else begin
      if (strobe.start) begin
        ptrQ    <= startAddrQ[ADDR_W-1:0];
        remainQ <= countQ;
      end
      if (strobe.fetch)   ptrQ    <= ptrQ + 1'b1;
      if (strobe.capture) dataQ   <= memRdata;
      if (strobe.handoff) remainQ <= remainQ - 1'b1;
    end
  end

  // sticky flags: hardware set wins over software clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneQ <= 1'b0;
      collQ <= 1'b0;
    end else begin
      if (strobe.finish)                 doneQ <= 1'b1;
      else if (wrStat && !regWdata[0])   doneQ <= 1'b0;
      if (cpuTxWrite && strobe.busy)     collQ <= 1'b1;
      else if (wrStat && !regWdata[1])   collQ <= 1'b0;
    end
  end

  always_comb begin
    regRdata = 8'h00;
    case (regAddr)
      REG_AW'(REG_CFG):   regRdata = {3'b000, busPrioQ, intPrioQ, intEnQ};
      REG_AW'(REG_CTRL):  regRdata = {7'b0000000, enableQ};
      REG_AW'(REG_STAT):  regRdata = {5'b00000, strobe.busy, collQ, doneQ};
      REG_AW'(REG_COUNT): regRdata = countQ;
      default: begin
        for (int b = 0; b < ADDR_BYTES; b++) begin
          if (regAddr == REG_AW'(int'(REG_ADDR0) + b)) regRdata = startAddrQ[b*8 +: 8];
        end
      end
    endcase
  end

  assign memAddr  = ptrQ;
  assign txData   = dataQ;
  assign enable   = enableQ;
  assign lastByte = (remainQ == '0);
  assign irq      = doneQ && intEnQ;
  assign intPrio  = intPrioQ;
  assign busPrio  = busPrioQ;
  assign doneFlag = doneQ;
  assign collFlag = collQ;

endmodule

// File: rtl/uart_tx_dma.sv
module uart_tx_dma
  import uart_tx_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memRdata,
  output logic              txValid,
  output logic [7:0]        txData,
  input  logic              txReady,
  input  logic              cpuTxWrite,
  output logic              irq,
  output logic [1:0]        intPrio,
  output logic [1:0]        busPrio
);

  dmaStrobe_t strobe;
  logic startReq, enable, lastByte;
  logic busyFlag, doneFlag, collFlag;

  assign busyFlag = strobe.busy;

  uart_tx_dma_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .enable   (enable),
    .lastByte (lastByte),
    .txReady  (txReady),
    .strobe   (strobe),
    .txValid  (txValid),
    .memReq   (memReq)
  );

  uart_tx_dma_dp #(
    .ADDR_W (ADDR_W),
    .REG_AW (REG_AW)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regWe      (regWe),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .memRdata   (memRdata),
    .cpuTxWrite (cpuTxWrite),
    .strobe     (strobe),
    .memAddr    (memAddr),
    .txData     (txData),
    .startReq   (startReq),
    .enable     (enable),
    .lastByte   (lastByte),
    .irq        (irq),
    .intPrio    (intPrio),
    .busPrio    (busPrio),
    .doneFlag   (doneFlag),
    .collFlag   (collFlag)
  );

endmodule

// File: rtl/uart_tx_dma_chk.sv
module uart_tx_dma_chk (
  input logic       clk,
  input logic       rstN,
  input logic       txValid,
  input logic       txReady,
  input logic [7:0] txData,
  input logic       memReq,
  input logic       regWe,
  input logic       cpuTxWrite,
  input logic       busyFlag,
  input logic       doneFlag,
  input logic       collFlag,
  input logic       irq
);

  assert_one_per_handshake_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txValid);

  assert_hold_until_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady && !regWe) |=> (txValid && $stable(txData)));

  assert_single_fetch_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  assert_collision_sets_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cpuTxWrite && busyFlag) |=> collFlag);

  assert_done_after_handover_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past(txValid && txReady));

  assert_irq_needs_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    !doneFlag |-> !irq);

  assert_fetch_only_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busyFlag);

endmodule

bind uart_tx_dma uart_tx_dma_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .txValid    (txValid),
  .txReady    (txReady),
  .txData     (txData),
  .memReq     (memReq),
  .regWe      (regWe),
  .cpuTxWrite (cpuTxWrite),
  .busyFlag   (busyFlag),
  .doneFlag   (doneFlag),
  .collFlag   (collFlag),
  .irq        (irq)
);

// File: tb/uart_tx_dma_bench.sv
`timescale 1ns/1ps
module uart_tx_dma_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [7:0]  regWdata = 8'h00;
  logic [7:0]  regRdata;
  logic        memReq;
  logic [15:0] memAddr;
  logic [7:0]  memRdata = 8'h00;
  logic        txValid;
  logic [7:0]  txData;
  logic        txReady = 1'b0;
  logic        cpuTxWrite = 1'b0;
  logic        irq;
  logic [1:0]  intPrio, busPrio;

  int checks = 0;
  int bad = 0;
  int readyMode = 0;
  int cyc = 0;
  logic [7:0] lfsr = 8'hB7;
  logic [7:0] rxBuf [0:511];
  int rxCount = 0;
  logic memReqSeen = 1'b0;

  always #5 clk = ~clk;

  uart_tx_dma u_uart_tx_dma (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .memReq(memReq), .memAddr(memAddr), .memRdata(memRdata),
    .txValid(txValid), .txData(txData), .txReady(txReady), .cpuTxWrite(cpuTxWrite),
    .irq(irq), .intPrio(intPrio), .busPrio(busPrio)
  );

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  // memory model: data one cycle after request
  always @(posedge clk) if (memReq) memRdata <= memByte(memAddr);

  // UART side: choose ready, then record the byte the next edge will take
  always @(negedge clk) begin
    logic r;
    cyc++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (readyMode)
      0: r = 1'b1;
      1: r = (cyc % 3) == 0;
      default: r = lfsr[0];
    endcase
    txReady = r;
    if (memReq) memReqSeen = 1'b1;
    if (txValid && r && rxCount < 512) begin
      rxBuf[rxCount] = txData;
      rxCount++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic waitIdle();
    logic [7:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(3'd2, s);
      if (!s[2]) break;
      @(negedge clk);
    end
  endtask

  task automatic startXfer(input int cnt, input logic [15:0] start, input int mode);
    logic [7:0] s;
    rxCount = 0;
    readyMode = mode;
    wr(3'd3, 8'(cnt));
    wr(3'd4, start[7:0]);
    wr(3'd5, start[15:8]);
    wr(3'd1, 8'h03);
    rd(3'd2, s);
    chk(s[2] == 1'b1, "R12 busy after start", s[2], 1);
  endtask

  task automatic checkBytes(input int n, input logic [15:0] start, input string req);
    int errs = 0;
    chk(rxCount == n, req, rxCount, n);
    for (int i = 0; i < n && i < rxCount; i++)
      if (rxBuf[i] !== memByte(start + 16'(i))) errs++;
    chk(errs == 0, "R3 R4 byte content", errs, 0);
  endtask

  task automatic runXfer(input int cnt, input logic [15:0] start, input int mode);
    logic [7:0] s;
    startXfer(cnt, start, mode);
    waitIdle();
    checkBytes(cnt + 1, start, "R3 byte count N+1");
    rd(3'd2, s);
    chk(s[2:0] == 3'b001, "R5 R12 done set busy clear", s[2:0], 1);
    wr(3'd2, 8'h00);
  endtask

  initial begin
    logic [7:0] s;
    int saved;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), s);
      chk(s == 8'h00, "R1 register reset", s, 0);
    end
    chk(!irq && !txValid && !memReq, "R1 outputs low in reset", {irq, txValid, memReq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!irq && !txValid && !memReq, "R1 outputs low after reset", {irq, txValid, memReq}, 0);

    // R9 priority fields, all combinations
    for (int v = 0; v < 16; v++) begin
      wr(3'd0, 8'(v << 1));
      rd(3'd0, s);
      chk(intPrio == 2'(v) && busPrio == 2'(v >> 2) && s == 8'(v << 1),
          "R9 priority passthrough", {busPrio, intPrio}, v);
    end
    wr(3'd0, 8'h00);

    // R2 enable gate and write-zero start
    memReqSeen = 1'b0;
    wr(3'd3, 8'd4);
    wr(3'd1, 8'h02);
    repeat (6) @(negedge clk);
    rd(3'd2, s);
    chk(!memReqSeen && !s[2], "R2 start with enable 0 ignored", memReqSeen, 0);
    wr(3'd1, 8'h01);
    repeat (6) @(negedge clk);
    rd(3'd2, s);
    chk(!memReqSeen && !s[2], "R2 enable without start ignored", memReqSeen, 0);
    wr(3'd1, 8'h00);

    // R3 R4 R5 sweep of lengths and ready patterns
    runXfer(0, 16'h0100, 0);
    runXfer(1, 16'h2345, 1);
    runXfer(2, 16'hFFFE, 2);
    runXfer(3, 16'h0010, 0);
    runXfer(7, 16'hFFFB, 1);
    runXfer(16, 16'h8000, 2);
    runXfer(255, 16'h1234, 0);
    runXfer(255, 16'hFF80, 2);

    // R6 interrupt and R5 stickiness, R8 write-one keeps
    wr(3'd0, 8'h01);
    startXfer(2, 16'h0400, 1);
    waitIdle();
    checkBytes(3, 16'h0400, "R3 byte count with irq");
    chk(irq == 1'b1, "R6 irq with done and enable", irq, 1);
    repeat (10) @(negedge clk);
    wr(3'd2, 8'h01);
    rd(3'd2, s);
    chk(s[0] == 1'b1 && irq, "R5 R8 done sticky under write 1", s[0], 1);
    wr(3'd2, 8'h00);
    rd(3'd2, s);
    chk(s[0] == 1'b0 && !irq, "R8 R6 done cleared by write 0", {s[0], irq}, 0);
    wr(3'd0, 8'h00);
    startXfer(0, 16'h0500, 0);
    waitIdle();
    rd(3'd2, s);
    chk(s[0] == 1'b1 && !irq, "R6 irq masked when disabled", irq, 0);
    wr(3'd2, 8'h00);

    // R10 start during transfer ignored
    startXfer(9, 16'h0700, 1);
    repeat (15) @(negedge clk);
    wr(3'd1, 8'h03);
    waitIdle();
    checkBytes(10, 16'h0700, "R10 restart ignored");
    wr(3'd2, 8'h00);

    // R7 R8 collision flag
    startXfer(20, 16'h0900, 1);
    @(negedge clk);
    cpuTxWrite = 1'b1;
    @(negedge clk);
    cpuTxWrite = 1'b0;
    rd(3'd2, s);
    chk(s[1] == 1'b1, "R7 collision during transfer", s[1], 1);
    cpuTxWrite = 1'b1; regWe = 1'b1; regAddr = 3'd2; regWdata = 8'h00;
    @(negedge clk);
    cpuTxWrite = 1'b0; regWe = 1'b0;
    rd(3'd2, s);
    chk(s[1] == 1'b1, "R8 hardware set wins over clear", s[1], 1);
    waitIdle();
    checkBytes(21, 16'h0900, "R7 transfer intact");
    rd(3'd2, s);
    chk(s[2:0] == 3'b011, "R7 R5 flags after transfer", s[2:0], 3);
    wr(3'd2, 8'h00);
    rd(3'd2, s);
    chk(s[1:0] == 2'b00, "R8 flags cleared", s[1:0], 0);
    @(negedge clk);
    cpuTxWrite = 1'b1;
    @(negedge clk);
    cpuTxWrite = 1'b0;
    rd(3'd2, s);
    chk(s[1] == 1'b0, "R7 idle write leaves flag", s[1], 0);

    // R11 abort
    startXfer(200, 16'h3000, 1);
    repeat (30) @(negedge clk);
    wr(3'd1, 8'h00);
    repeat (3) @(negedge clk);
    rd(3'd2, s);
    chk(s[2:0] == 3'b000, "R11 abort idle without done", s[2:0], 0);
    saved = rxCount;
    repeat (30) @(negedge clk);
    chk(rxCount == saved && !txValid && saved < 201, "R11 no bytes after abort", rxCount, saved);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule